// File: doc/BRIEF.md
# Floating-Point Add Alignment Stage

This block is the front pipeline stage of a double-precision floating-point adder/subtractor. It takes two 64-bit binary64 operands and an operation bit (0 for add, 1 for subtract). It splits each operand into sign, biased exponent and fraction, restores the implicit leading bit, and works out whether the signed sum is really an addition or a subtraction of magnitudes. It then decides which operand has the larger magnitude and aligns the other operand's significand to it.

The smaller significand is extended by a guard bit and a round bit and shifted right by the exponent difference. The shift amount is six bits wide and saturates at 63. Every bit that falls off the right end is OR-reduced into a sticky bit. When the operation is an effective subtraction, the aligned value is one's-complemented. Everything is registered, so the next stage (significand add, rounding, normalization, packing) sees the results exactly one clock later.

Operands whose exponent field is all ones (infinity or NaN) are not processed arithmetically. The stage raises a flag and registers a ready-made special result, which the next stage forwards unchanged.

Top module: `fpadd_align_stage`

## Requirements
- R1: `eff_sub` equals sign(A) XOR sign(B) XOR `op_sub` (bit 63 is the sign of each operand). The sign sits at bit 63, the 11-bit biased exponent at bits 62:52 and the fraction at bits 51:0.
- R2: The implicit bit of a significand is 1 when its exponent field is nonzero and 0 when it is zero. `big_sig` is {implicit bit, fraction} of the larger operand.
- R3: For the difference computation, an exponent field of 0 counts as exponent 1. The shift amount is min(|eA' − eB'|, 63).
- R4: The larger operand is the one with the larger value of bits 62:0 taken as an unsigned number. On a tie, A is chosen. `big_exp` is that operand's exponent field.
- R5: `res_sign` is the sign of A when A is larger. Otherwise it is the sign of B XOR `op_sub`.
- R6: `small_sig` is the smaller operand's significand with two zero bits appended below it (55 bits), shifted right by the shift amount. A shift of 55 or more gives zero.
- R7: `sticky` is the OR of all bits of that 55-bit value that are shifted out. It is 0 when the shift amount is 2 or less.
- R8: When `eff_sub` is 1, `small_sig` holds the bitwise complement of the aligned value. `sticky` is never complemented.
- R9: `special` is 1 when either exponent field is all ones. `special_val` then follows these rules:
  - Any NaN input, or infinities of opposite effective sign, gives 0x7FF8000000000000.
  - Otherwise an infinite A is passed through unchanged.
  - Otherwise an infinite B is passed with its sign XOR `op_sub`.
  - When `special` is 0, `special_val` is 0.
- R10: All outputs are zero while `rst_n` is low. Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 64 | Operand A, binary64 |
| opb | input | 64 | Operand B, binary64 |
| op_sub | input | 1 | 1 requests A − B, 0 requests A + B |
| eff_sub | output | 1 | Effective magnitude subtraction |
| res_sign | output | 1 | Provisional sign of the result |
| big_exp | output | 11 | Exponent field of the larger operand |
| big_sig | output | 53 | Significand of the larger operand |
| small_sig | output | 55 | Aligned (and conditionally inverted) smaller significand with guard and round |
| sticky | output | 1 | OR of bits shifted past the round position |
| special | output | 1 | An operand is infinity or NaN |
| special_val | output | 64 | Final result to forward when `special` is set |

## Verification
The assertions assume that `opa`, `opb` and `op_sub` carry known values at every rising edge after reset. The registered-latency checks compare against `$past` of those inputs, so an unknown input would make those checks meaningless. The bench drives all three inputs from time zero and changes them only on falling edges. Its random exponent pairs are drawn so that differences fall near 0, at the 2/55/63/64 boundaries, and far beyond the saturation point. Directed vectors add subnormals, exact ties, zeros and every infinity/NaN combination.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int GR_W    = 2;
  localparam int ALN_W   = SIG_W + GR_W;
  localparam int AMT_W   = 6;
  localparam int AMT_MAX = (1 << AMT_W) - 1;

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  sig;
    logic [EXP_W-1:0]  eexp;
    logic              is_inf;
    logic              is_nan;
  } opnd_t;

  function automatic logic [AMT_W-1:0] sat_amt(input logic [EXP_W:0] d);
    if (d > AMT_MAX[EXP_W:0]) return AMT_MAX[AMT_W-1:0];
    return d[AMT_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] qnan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] inf_of(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output opnd_t             fld
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic              hid;

  assign e   = word[WORD_W-2 -: EXP_W];
  assign f   = word[FRAC_W-1:0];
  assign hid = |e;

  always_comb begin
    fld.sgn    = word[WORD_W-1];
    fld.exp    = e;
    fld.sig    = {hid, f};
    fld.eexp   = hid ? e : {{(EXP_W-1){1'b0}}, 1'b1};
    fld.is_inf = (&e) && !(|f);
    fld.is_nan = (&e) && (|f);
  end
endmodule

// File: rtl/fpa_expcmp.sv
module fpa_expcmp
  import fpa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  opnd_t            a,
  input  opnd_t            b,
  output logic             a_big,
  output logic [AMT_W-1:0] amt
);
  logic [EXP_W:0] d_ab;
  logic [EXP_W:0] d_ba;
  logic [EXP_W:0] mag;
  logic           exp_tie;

  assign d_ab    = {1'b0, a.eexp} - {1'b0, b.eexp};
  assign d_ba    = {1'b0, b.eexp} - {1'b0, a.eexp};
  assign exp_tie = (d_ab == '0);
  assign a_big   = !d_ab[EXP_W] && (!exp_tie || (a.sig >= b.sig));
  assign mag     = d_ab[EXP_W] ? d_ba : d_ab;
  assign amt     = sat_amt(mag);

  // R3
  amt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag > AMT_MAX[EXP_W:0]) |-> (amt == AMT_MAX[AMT_W-1:0]));

  // R4
  tie_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a.eexp == b.eexp) && (a.sig == b.sig)) |-> a_big);
endmodule

// File: rtl/fpa_shifter.sv
module fpa_shifter
  import fpa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIG_W-1:0] sig,
  input  logic [AMT_W-1:0] amt,
  input  logic             inv,
  output logic [ALN_W-1:0] aligned,
  output logic             sticky
);
  localparam int EXT_W = ALN_W + AMT_MAX;

  logic [EXT_W-1:0] ext;
  logic [ALN_W-1:0] kept;

  assign ext     = {sig, {GR_W{1'b0}}, {AMT_MAX{1'b0}}} >> amt;
  assign kept    = ext[EXT_W-1 -: ALN_W];
  assign sticky  = |ext[AMT_MAX-1:0];
  assign aligned = inv ? ~kept : kept;

  // R7
  sticky_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amt <= AMT_W'(GR_W)) |-> !sticky);
endmodule

// File: rtl/fpadd_align_stage.sv
module fpadd_align_stage
  import fpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       opa,
  input  logic [63:0]       opb,
  input  logic              op_sub,
  output logic              eff_sub,
  output logic              res_sign,
  output logic [10:0]       big_exp,
  output logic [52:0]       big_sig,
  output logic [54:0]       small_sig,
  output logic              sticky,
  output logic              special,
  output logic [63:0]       special_val
);
  logic [WORD_W-1:0] words [2];
  opnd_t             fld   [2];

  assign words[0] = opa;
  assign words[1] = opb;

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fpa_unpack u_unp (.word(words[i]), .fld(fld[i]));
  end

  logic             sub_w;
  logic             a_big;
  logic [AMT_W-1:0] amt;
  opnd_t            lg;
  opnd_t            sm;
  logic [ALN_W-1:0] aligned_w;
  logic             sticky_w;
  logic             sign_w;
  logic             spec_w;
  logic [WORD_W-1:0] spec_val_w;
  logic             b_eff_sgn;

  assign sub_w     = fld[0].sgn ^ fld[1].sgn ^ op_sub;
  assign b_eff_sgn = fld[1].sgn ^ op_sub;

  fpa_expcmp u_cmp (
    .clk(clk), .rst_n(rst_n), .a(fld[0]), .b(fld[1]), .a_big(a_big), .amt(amt)
  );

  assign lg     = a_big ? fld[0] : fld[1];
  assign sm     = a_big ? fld[1] : fld[0];
  assign sign_w = a_big ? fld[0].sgn : b_eff_sgn;

  fpa_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .sig(sm.sig), .amt(amt), .inv(sub_w),
    .aligned(aligned_w), .sticky(sticky_w)
  );

  always_comb begin
    spec_w     = (&fld[0].exp) || (&fld[1].exp);
    spec_val_w = '0;
    if (spec_w) begin
      if (fld[0].is_nan || fld[1].is_nan)          spec_val_w = qnan();
      else if (fld[0].is_inf && fld[1].is_inf)     spec_val_w = sub_w ? qnan() : opa;
      else if (fld[0].is_inf)                      spec_val_w = opa;
      else                                         spec_val_w = inf_of(b_eff_sgn);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_sub     <= 1'b0;
      res_sign    <= 1'b0;
      big_exp     <= '0;
      big_sig     <= '0;
      small_sig   <= '0;
      sticky      <= 1'b0;
      special     <= 1'b0;
      special_val <= '0;
    end else begin
      eff_sub     <= sub_w;
      res_sign    <= sign_w;
      big_exp     <= lg.exp;
      big_sig     <= lg.sig;
      small_sig   <= aligned_w;
      sticky      <= sticky_w;
      special     <= spec_w;
      special_val <= spec_val_w;
    end
  end

  // R1
  effsub_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_sub == ($past(opa[63]) ^ $past(opb[63]) ^ $past(op_sub)));

  // R2
  hidden_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    big_sig[52] == (big_exp != '0));

  // R9
  special_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !special |-> ((big_exp != '1) && (special_val == '0)));

  // R4
  big_exp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (big_exp == $past(opa[62:52])) || (big_exp == $past(opb[62:52])));
endmodule

// File: tb/fpadd_align_stage_test.sv
`timescale 1ns/1ps
module fpadd_align_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        op_sub = 1'b0;
  logic        eff_sub, res_sign, sticky, special;
  logic [10:0] big_exp;
  logic [52:0] big_sig;
  logic [54:0] small_sig;
  logic [63:0] special_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fpadd_align_stage uut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op_sub(op_sub),
    .eff_sub(eff_sub), .res_sign(res_sign), .big_exp(big_exp), .big_sig(big_sig),
    .small_sig(small_sig), .sticky(sticky), .special(special), .special_val(special_val)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h sub=%b)", tag, act, exp_v, opa, opb, op_sub);
    end
  endtask

  function automatic logic [10:0] eadj(input logic [10:0] e);
    return (e == 0) ? 11'd1 : e;
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic s);
    logic        x_sub, a_wins, x_sign, x_sticky, x_spec;
    logic [63:0] lg, sm, x_sv;
    logic [54:0] s55, x_small;
    int          diff, sh;
    @(negedge clk);
    opa = a; opb = b; op_sub = s;
    x_sub  = a[63] ^ b[63] ^ s;
    a_wins = (a[62:0] >= b[62:0]);
    lg = a_wins ? a : b;
    sm = a_wins ? b : a;
    x_sign = a_wins ? a[63] : (b[63] ^ s);
    diff = int'(eadj(lg[62:52])) - int'(eadj(sm[62:52]));
    sh = (diff > 63) ? 63 : diff;
    s55 = {(sm[62:52] != 0), sm[51:0], 2'b00};
    x_small = (sh >= 55) ? 55'd0 : (s55 >> sh);
    x_sticky = 1'b0;
    for (int i = 0; i < 55; i++) if (i < sh) x_sticky |= s55[i];
    if (x_sub) x_small = ~x_small;
    x_spec = (a[62:52] == 11'h7FF) || (b[62:52] == 11'h7FF);
    x_sv = 64'd0;
    if (x_spec) begin
      logic na, nb, ia, ib;
      na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      ia = (a[62:52] == 11'h7FF) && !na;
      ib = (b[62:52] == 11'h7FF) && !nb;
      if (na || nb || (ia && ib && (a[63] != (b[63] ^ s)))) x_sv = 64'h7FF8000000000000;
      else if (ia) x_sv = a;
      else x_sv = {b[63] ^ s, 11'h7FF, 52'd0};
    end
    @(posedge clk); #1;
    chk("R1 eff_sub", {63'd0, eff_sub}, {63'd0, x_sub});
    chk("R4 big_exp", {53'd0, big_exp}, {53'd0, lg[62:52]});
    chk("R2 big_sig", {11'd0, big_sig}, {11'd0, (lg[62:52] != 0), lg[51:0]});
    chk("R5 res_sign", {63'd0, res_sign}, {63'd0, x_sign});
    chk(x_sub ? "R8 small_sig inverted" : "R6 R3 small_sig", {9'd0, small_sig}, {9'd0, x_small});
    chk("R7 sticky", {63'd0, sticky}, {63'd0, x_sticky});
    chk("R9 special", {63'd0, special}, {63'd0, x_spec});
    chk("R9 special_val", special_val, x_sv);
  endtask

  function automatic logic [63:0] mk(input logic sg, input logic [10:0] e, input logic [51:0] f);
    return {sg, e, f};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] ra, rb;
    logic [10:0] ea, eb;
    int          seed;
    seed = 32'h1D2C3B4A;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 reset eff_sub", {63'd0, eff_sub}, 64'd0);
    chk("R10 reset small_sig", {9'd0, small_sig}, 64'd0);
    chk("R10 reset special_val", special_val, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    apply(mk(0, 11'h400, 52'h8_0000_0000_0001), mk(0, 11'h400, 52'h8_0000_0000_0001), 1'b1); // R4 tie, R8
    apply(mk(1, 11'h400, 52'h1), mk(0, 11'h400, 52'h2), 1'b0);    // R4 B wins on significand, R5
    apply(mk(0, 11'h000, 52'hF_FFFF_FFFF_FFFF), mk(0, 11'h001, 52'h0), 1'b0); // R3 subnormal vs exp 1
    apply(mk(0, 11'h000, 52'h3), mk(1, 11'h000, 52'h5), 1'b1);    // R2 both subnormal
    apply(mk(0, 11'h402, 52'h3), mk(0, 11'h400, 52'h3), 1'b0);    // R7 shift 2 no sticky
    apply(mk(0, 11'h403, 52'h7), mk(0, 11'h400, 52'h7), 1'b1);    // R7 shift 3 sticky
    apply(mk(0, 11'h437, 52'h0), mk(1, 11'h400, 52'h1), 1'b0);    // R6 shift 55
    apply(mk(0, 11'h43F, 52'h0), mk(0, 11'h400, 52'h0), 1'b0);    // R3 shift 63
    apply(mk(0, 11'h440, 52'h0), mk(0, 11'h400, 52'h1), 1'b1);    // R3 saturate 64
    apply(mk(0, 11'h7FE, 52'h0), mk(1, 11'h001, 52'h0), 1'b0);    // R3 huge diff
    apply(64'd0, 64'h8000000000000000, 1'b0);                      // zeros
    apply(mk(0, 11'h7FF, 52'h0), mk(0, 11'h400, 52'h0), 1'b0);    // R9 inf A
    apply(mk(0, 11'h400, 52'h0), mk(0, 11'h7FF, 52'h0), 1'b1);    // R9 inf B, sub
    apply(mk(0, 11'h7FF, 52'h0), mk(0, 11'h7FF, 52'h0), 1'b1);    // R9 inf - inf
    apply(mk(1, 11'h7FF, 52'h0), mk(0, 11'h7FF, 52'h0), 1'b1);    // R9 -inf - inf
    apply(mk(0, 11'h7FF, 52'h1), mk(0, 11'h400, 52'h0), 1'b0);    // R9 NaN
    apply(mk(0, 11'h3FF, 52'h0), mk(0, 11'h7FF, 52'h8_0000_0000_0000), 1'b0);

    for (int n = 0; n < 3000; n++) begin
      ea = 11'($urandom_range(0, 2046));
      case ($urandom_range(0, 3))
        0: eb = ea;
        1: eb = 11'((int'(ea) + $urandom_range(0, 70)) % 2047);
        2: eb = 11'((int'(ea) + 2047 - $urandom_range(0, 70)) % 2047);
        default: eb = 11'($urandom_range(0, 2047));
      endcase
      if ($urandom_range(0, 50) == 0) ea = 11'h7FF;
      ra = {1'($urandom), ea, $urandom, 20'($urandom)};
      rb = {1'($urandom), eb, $urandom, 20'($urandom)};
      if ($urandom_range(0, 9) == 0) rb[51:0] = ra[51:0];
      apply(ra, rb, 1'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule